// File: doc/BRIEF.md
# Auto-Increment Dual Transfer Buffer

This block is the staging memory for block transfers that do not use DMA. It holds two buffers of 64 words, each word 64 bits wide, which is 512 bytes per buffer. On one side a host register port sees two registers. The index register selects a buffer, a word offset and whether accesses advance the offset. The data register reads or writes the word that the index points at. Software streams a whole block through the data register by programming the index once and then hitting the data register repeatedly.

On the other side a card data engine moves one byte at a time. The engine arms the block with a buffer number and a length in words. A transfer always ends at the last word of its buffer, so the engine begins at word 64 minus the length. Bytes are packed most significant first: the first byte of a transfer occupies bits 63:56 of its word. When the final byte of word 63 has been handled, the block raises a one-cycle completion pulse and the engine side goes idle.

Top module: `dbuf_xfer_top`

## Requirements
- R1: After a synchronous active-low reset, the index register reads as zero, the engine side is idle and `eng_done` is low.
- R2: Writing the index register (`host_addr`=0) loads the word offset from bits 5:0, the buffer select from bit 6 and the advance enable from bit 16. A read of the index register returns those three fields in the same positions, with every other bit zero.
- R3: With the advance bit set, each data-register access (`host_addr`=1, a read or a write) moves the offset forward by one. Offset 63 wraps to 0, and the buffer select does not change.
- R4: With the advance bit clear, data-register accesses leave the offset, the buffer select and the advance bit unchanged.
- R5: A data-register read returns the word at the selected buffer and offset. A data-register write stores `host_wdata` there. The two buffers hold separate contents.
- R6: `eng_start` with length L places the engine at word (64 − L) mod 64 of buffer `eng_buf`. L = 64 and L = 0 both start at word 0.
- R7: Engine write bytes fill a word from bits 63:56 downward. The word is stored only when its eighth byte arrives, and the engine then moves to the next word.
- R8: `eng_rbyte` shows the byte of the current word at the current byte position, starting at bits 63:56. Each `eng_rd` advances one byte, and after the eighth byte it advances to the next word.
- R9: `eng_done` is high for exactly one cycle, the cycle after the last byte of word 63 is accepted. The engine is then idle, and `eng_wr` or `eng_rd` has no effect until the next `eng_start`.
- R10: When an engine word store and a host data write hit the same word in the same cycle, the engine data is kept. A host write to a different word in that cycle also takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 1 | Register select: 0 index, 1 data |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (a data read may advance the offset) |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data for the selected register (combinational) |
| eng_start | input | 1 | Arms the engine for a new block |
| eng_buf | input | 1 | Buffer used by the armed block |
| eng_len | input | 7 | Block length in words (0 means 64) |
| eng_wr | input | 1 | Engine byte write strobe |
| eng_wbyte | input | 8 | Engine write byte |
| eng_rd | input | 1 | Engine byte read advance strobe |
| eng_rbyte | output | 8 | Current engine read byte (combinational) |
| eng_done | output | 1 | One-cycle completion pulse for the block |

## Verification
The host side is tried with three index patterns. The first has advance enabled near the top of each buffer, which separates a wrapping offset from one that carries into the buffer select. The second has advance disabled, which separates a held offset from a moving one. The third writes junk in the unused index bits, which shows whether the readback mask is right. The engine side is walked over a table of lengths (1, 8, 33, 64 and 0), each with its own byte pattern; reading the landing word back through the host port shows both the start offset and the byte order. Directed cases check a partly filled word before and after its eighth byte, reads that cross a word boundary, the completion pulse and the idle state after it, and same-cycle host and engine writes to the same word and to different words.

// File: rtl/dbuf_pkg.sv
// Shared constants and types for the dual transfer buffer.
// Assumes the buffer select field sits directly above the word offset.
package dbuf_pkg;
    // Default geometry: two buffers of 64 words of 64 bits
    localparam int DEF_DW    = 64;
    localparam int DEF_WORDS = 64;
    localparam int DEF_NBUF  = 2;

    // Bit position of the advance-enable flag in the index register
    localparam int IDX_INC_BIT = 16;

    // Host register select
    typedef enum logic {
        HREG_INDEX = 1'b0,
        HREG_DATA  = 1'b1
    } hreg_e;
endpackage

// File: rtl/dbuf_idx_reg.sv
// Host index register: word offset, buffer select and advance enable.
// Assumes an index write and a data access never occur in the same cycle
// (they use different register selects). Offset wraps inside the buffer.
module dbuf_idx_reg #(
    parameter int DW      = 64,
    parameter int OFF_W   = 6,
    parameter int BUF_W   = 1,
    parameter int INC_BIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_we,
    input  logic [DW-1:0]    wdata,
    input  logic             data_acc,
    output logic [OFF_W-1:0] off,
    output logic [BUF_W-1:0] bsel,
    output logic             inc
);
    // Load fields on an index write, otherwise step the offset on a data access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off  <= '0;
            bsel <= '0;
            inc  <= 1'b0;
        end else if (idx_we) begin
            off  <= wdata[OFF_W-1:0];
            bsel <= wdata[OFF_W +: BUF_W];
            inc  <= wdata[INC_BIT];
        end else if (data_acc && inc) begin
            off  <= off + 1'b1;
        end
    end
endmodule

// File: rtl/dbuf_store.sv
// Word storage for all buffers with two write ports and two read ports.
// Assumes DEPTH is a power of two. Contents are not reset; software fills a
// buffer before reading it. The engine write wins a same-address collision.
module dbuf_store #(
    parameter int DW    = 64,
    parameter int DEPTH = 128,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          h_we,
    input  logic [AW-1:0] h_waddr,
    input  logic [DW-1:0] h_wdata,
    input  logic          e_we,
    input  logic [AW-1:0] e_waddr,
    input  logic [DW-1:0] e_wdata,
    input  logic [AW-1:0] h_raddr,
    output logic [DW-1:0] h_rdata,
    input  logic [AW-1:0] e_raddr,
    output logic [DW-1:0] e_rdata
);
    logic [DW-1:0] mem [DEPTH];
    logic          h_blocked;

    // Host write is dropped only when the engine stores the same word
    assign h_blocked = e_we && (e_waddr == h_waddr);

    // Commit both write ports, engine last
    always_ff @(posedge clk) begin
        if (h_we && !h_blocked) begin
            mem[h_waddr] <= h_wdata;
        end
        if (e_we) begin
            mem[e_waddr] <= e_wdata;
        end
    end

    // Asynchronous read ports
    assign h_rdata = mem[h_raddr];
    assign e_rdata = mem[e_raddr];
endmodule

// File: rtl/dbuf_eng_seq.sv
// Engine-side byte sequencer. It arms on a start pulse at word WORDS-len and
// packs or unpacks bytes most significant first. It stores a word on the eighth
// written byte and pulses done after the final byte of the last word.
// Assumes DW is a multiple of 8 and at least 16. A write and a read strobe in
// the same cycle count as one write step.
module dbuf_eng_seq #(
    parameter int DW    = 64,
    parameter int WORDS = 64,
    parameter int OFF_W = 6,
    parameter int BUF_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eng_start,
    input  logic [BUF_W-1:0] eng_buf,
    input  logic [OFF_W:0]   eng_len,
    input  logic             eng_wr,
    input  logic [7:0]       eng_wbyte,
    input  logic             eng_rd,
    input  logic [DW-1:0]    rd_word,
    output logic [7:0]       eng_rbyte,
    output logic             active,
    output logic [BUF_W-1:0] bufq,
    output logic [OFF_W-1:0] wptr,
    output logic [$clog2(DW/8)-1:0] bidx,
    output logic             mem_we,
    output logic [DW-1:0]    mem_wdata,
    output logic             done
);
    localparam int BPW   = DW / 8;
    localparam int BI_W  = $clog2(BPW);
    localparam int LEN_W = OFF_W + 1;

    logic [DW-9:0]      acc;
    logic [LEN_W-1:0]   start_diff;
    logic               step;
    logic               last_byte;
    logic               last_word;
    logic [BI_W+2:0]    shamt;
    logic [DW-1:0]      shifted;

    assign start_diff = LEN_W'(WORDS) - eng_len;
    assign step       = active && (eng_wr || eng_rd);
    assign last_byte  = (bidx == BI_W'(BPW - 1));
    assign last_word  = (wptr == OFF_W'(WORDS - 1));

    // Word store on the eighth written byte
    assign mem_we    = active && eng_wr && last_byte;
    assign mem_wdata = {acc, eng_wbyte};

    // Select the current read byte, highest byte first
    assign shamt     = {BI_W'(BPW - 1) - bidx, 3'b000};
    assign shifted   = rd_word >> shamt;
    assign eng_rbyte = shifted[7:0];

    // Sequencer state: arm, step bytes, step words, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            bufq   <= '0;
            wptr   <= '0;
            bidx   <= '0;
            acc    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (eng_start) begin
                active <= 1'b1;
                bufq   <= eng_buf;
                wptr   <= start_diff[OFF_W-1:0];
                bidx   <= '0;
            end else if (step) begin
                bidx <= bidx + 1'b1;
                if (eng_wr) begin
                    acc <= {acc[DW-17:0], eng_wbyte};
                end
                if (last_byte) begin
                    wptr <= wptr + 1'b1;
                    if (last_word) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dbuf_xfer_top.sv
// Dual transfer buffer top: host index/data register pair on one side and a
// byte-serial engine port on the other, sharing one word store.
// Assumes NBUF is a power of two and host strobes are single-cycle qualified.
module dbuf_xfer_top
    import dbuf_pkg::*;
#(
    parameter int  DW    = DEF_DW,
    parameter int  WORDS = DEF_WORDS,
    parameter int  NBUF  = DEF_NBUF,
    localparam int OFF_W = $clog2(WORDS),
    localparam int BUF_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_addr,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [DW-1:0]    host_wdata,
    output logic [DW-1:0]    host_rdata,
    input  logic             eng_start,
    input  logic [BUF_W-1:0] eng_buf,
    input  logic [OFF_W:0]   eng_len,
    input  logic             eng_wr,
    input  logic [7:0]       eng_wbyte,
    input  logic             eng_rd,
    output logic [7:0]       eng_rbyte,
    output logic             eng_done
);
    localparam int AW    = BUF_W + OFF_W;
    localparam int DEPTH = NBUF * WORDS;
    localparam int BI_W  = $clog2(DW / 8);

    logic             sel_data;
    logic             idx_we;
    logic             data_acc;
    logic             h_we;
    logic [OFF_W-1:0] idx_off;
    logic [BUF_W-1:0] idx_bsel;
    logic             idx_inc;
    logic [DW-1:0]    idx_view;
    logic [DW-1:0]    h_rdata;
    logic [DW-1:0]    e_rdata;
    logic             eng_active;
    logic [BUF_W-1:0] eng_bufq;
    logic [OFF_W-1:0] eng_wptr;
    logic [BI_W-1:0]  eng_bidx;
    logic             e_we;
    logic [DW-1:0]    e_wdata;

    // Host strobe decode
    assign sel_data = (hreg_e'(host_addr) == HREG_DATA);
    assign idx_we   = !sel_data && host_wr;
    assign h_we     = sel_data && host_wr;
    assign data_acc = sel_data && (host_wr || host_rd);

    dbuf_idx_reg #(
        .DW(DW), .OFF_W(OFF_W), .BUF_W(BUF_W), .INC_BIT(IDX_INC_BIT)
    ) u_idx (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .wdata(host_wdata),
        .data_acc(data_acc), .off(idx_off), .bsel(idx_bsel), .inc(idx_inc)
    );

    dbuf_eng_seq #(
        .DW(DW), .WORDS(WORDS), .OFF_W(OFF_W), .BUF_W(BUF_W)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .eng_buf(eng_buf),
        .eng_len(eng_len), .eng_wr(eng_wr), .eng_wbyte(eng_wbyte),
        .eng_rd(eng_rd), .rd_word(e_rdata), .eng_rbyte(eng_rbyte),
        .active(eng_active), .bufq(eng_bufq), .wptr(eng_wptr),
        .bidx(eng_bidx), .mem_we(e_we), .mem_wdata(e_wdata), .done(eng_done)
    );

    dbuf_store #(
        .DW(DW), .DEPTH(DEPTH), .AW(AW)
    ) u_store (
        .clk(clk),
        .h_we(h_we), .h_waddr({idx_bsel, idx_off}), .h_wdata(host_wdata),
        .e_we(e_we), .e_waddr({eng_bufq, eng_wptr}), .e_wdata(e_wdata),
        .h_raddr({idx_bsel, idx_off}), .h_rdata(h_rdata),
        .e_raddr({eng_bufq, eng_wptr}), .e_rdata(e_rdata)
    );

    // Assemble the index register view with unused bits zero
    always_comb begin
        idx_view                 = '0;
        idx_view[OFF_W-1:0]      = idx_off;
        idx_view[OFF_W +: BUF_W] = idx_bsel;
        idx_view[IDX_INC_BIT]    = idx_inc;
    end

    // Host read mux
    assign host_rdata = sel_data ? h_rdata : idx_view;
endmodule

// File: rtl/dbuf_xfer_chk.sv
// Property checker for dbuf_xfer_top, attached by bind. Observes host strobes,
// index state and engine sequencer state driven by separate submodules.
module dbuf_xfer_chk #(
    parameter int OFF_W = 6,
    parameter int BUF_W = 1,
    parameter int BI_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_addr,
    input logic             host_wr,
    input logic             host_rd,
    input logic [OFF_W-1:0] idx_off,
    input logic [BUF_W-1:0] idx_bsel,
    input logic             idx_inc,
    input logic             eng_start,
    input logic             eng_wr,
    input logic             eng_rd,
    input logic             eng_active,
    input logic [OFF_W-1:0] eng_wptr,
    input logic [BI_W-1:0]  eng_bidx,
    input logic             eng_done
);
    logic             data_access;
    logic [OFF_W-1:0] off_plus1;

    assign data_access = host_addr && (host_wr || host_rd);
    assign off_plus1   = idx_off + 1'b1;

    // R1: reset clears index and engine state
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (idx_off == '0) && (idx_bsel == '0) && !idx_inc
                   && !eng_active && !eng_done);

    // R3: advance moves the offset by one and keeps the buffer
    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (data_access && idx_inc) |=> (idx_off == $past(off_plus1))
                                     && $stable(idx_bsel));

    // R4: no advance leaves the index alone
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (data_access && !idx_inc) |=> $stable(idx_off) && $stable(idx_bsel)
                                      && !idx_inc);

    // R6: start arms the engine at the first byte
    a_r6_arm: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> eng_active && (eng_bidx == '0));

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !eng_done);

    // R9: completion leaves the engine idle
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |-> !eng_active);

    // R9: strobes while idle do not move the engine
    a_r9_idle_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_active && !eng_start && (eng_wr || eng_rd))
            |=> $stable(eng_wptr) && $stable(eng_bidx) && !eng_active);
endmodule

bind dbuf_xfer_top dbuf_xfer_chk #(
    .OFF_W(OFF_W), .BUF_W(BUF_W), .BI_W(BI_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .idx_off(idx_off), .idx_bsel(idx_bsel),
    .idx_inc(idx_inc), .eng_start(eng_start), .eng_wr(eng_wr),
    .eng_rd(eng_rd), .eng_active(eng_active), .eng_wptr(eng_wptr),
    .eng_bidx(eng_bidx), .eng_done(eng_done)
);

// File: tb/dbuf_xfer_top_tb_top.sv
`timescale 1ns/1ps
module dbuf_xfer_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_addr = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        eng_start = 1'b0;
    logic [0:0]  eng_buf = '0;
    logic [6:0]  eng_len = '0;
    logic        eng_wr = 1'b0;
    logic [7:0]  eng_wbyte = '0;
    logic        eng_rd = 1'b0;
    logic [7:0]  eng_rbyte;
    logic        eng_done;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dbuf_xfer_top dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_start(eng_start), .eng_buf(eng_buf), .eng_len(eng_len),
        .eng_wr(eng_wr), .eng_wbyte(eng_wbyte), .eng_rd(eng_rd),
        .eng_rbyte(eng_rbyte), .eng_done(eng_done)
    );

    // Engine length table: {len[6:0], expected start word[5:0]}
    localparam logic [12:0] VEC [5] = '{
        {7'd1,  6'd63},
        {7'd8,  6'd56},
        {7'd33, 6'd31},
        {7'd64, 6'd0},
        {7'd0,  6'd0}
    };

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic hwr(logic a, logic [63:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1 host_wr = 1'b0;
    endtask

    task automatic hrd(logic a, output logic [63:0] q);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 q = host_rdata;
        @(posedge clk); #1 host_rd = 1'b0;
    endtask

    task automatic estart(logic bf, logic [6:0] len);
        @(negedge clk);
        eng_start = 1'b1; eng_buf = bf; eng_len = len;
        @(posedge clk); #1 eng_start = 1'b0;
    endtask

    task automatic ewr(logic [7:0] b);
        @(negedge clk);
        eng_wr = 1'b1; eng_wbyte = b;
        @(posedge clk); #1 eng_wr = 1'b0;
    endtask

    task automatic erd(output logic [7:0] q);
        @(negedge clk);
        eng_rd = 1'b1;
        #1 q = eng_rbyte;
        @(posedge clk); #1 eng_rd = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog act=timeout exp=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] q;
        logic [7:0]  b;
        logic [63:0] exp_w;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1 chk("R1 done low in reset", 64'(eng_done), 64'h0);
        @(negedge clk); rst_n = 1'b1;
        hrd(1'b0, q);
        chk("R1 index after reset", q, 64'h0);
        chk("R1 done after reset", 64'(eng_done), 64'h0);

        // R2: field load and masked readback
        hwr(1'b0, 64'hDEAD_BEEF_0001_FFC5);
        hrd(1'b0, q);
        chk("R2 index readback", q, 64'h0000_0000_0001_0045);

        // R3: advance with wrap in buffer 0 and buffer 1
        hwr(1'b0, 64'h1003E);
        hwr(1'b1, 64'hA0A0_0000_0000_0062);
        hwr(1'b1, 64'hA1A1_0000_0000_0063);
        hwr(1'b1, 64'hA2A2_0000_0000_0000);
        hrd(1'b0, q);
        chk("R3 wrap buffer 0", q, 64'h10001);
        hwr(1'b0, 64'h1007E);
        hwr(1'b1, 64'hB0B0_0000_0000_0062);
        hwr(1'b1, 64'hB1B1_0000_0000_0063);
        hwr(1'b1, 64'hB2B2_0000_0000_0000);
        hrd(1'b0, q);
        chk("R3 wrap keeps buffer 1", q, 64'h10041);

        // R5: read back both buffers through advancing reads
        hwr(1'b0, 64'h1003E);
        hrd(1'b1, q); chk("R5 buf0 w62", q, 64'hA0A0_0000_0000_0062);
        hrd(1'b1, q); chk("R5 buf0 w63", q, 64'hA1A1_0000_0000_0063);
        hrd(1'b1, q); chk("R5 buf0 w0",  q, 64'hA2A2_0000_0000_0000);
        hrd(1'b0, q); chk("R3 read advance", q, 64'h10001);
        hwr(1'b0, 64'h1007E);
        hrd(1'b1, q); chk("R5 buf1 w62", q, 64'hB0B0_0000_0000_0062);
        hrd(1'b1, q); chk("R5 buf1 w63", q, 64'hB1B1_0000_0000_0063);
        hrd(1'b1, q); chk("R5 buf1 w0",  q, 64'hB2B2_0000_0000_0000);

        // R4: advance clear keeps the index
        hwr(1'b0, 64'h0000A);
        hwr(1'b1, 64'hD1D1_D1D1_D1D1_D1D1);
        hwr(1'b1, 64'hD2D2_D2D2_D2D2_D2D2);
        hrd(1'b0, q); chk("R4 index held after writes", q, 64'h0000A);
        hrd(1'b1, q); chk("R4 same word overwritten", q, 64'hD2D2_D2D2_D2D2_D2D2);
        hrd(1'b0, q); chk("R4 index held after read", q, 64'h0000A);

        // R6 / R7: table of engine lengths, check the landing word via host
        for (int i = 0; i < 5; i++) begin
            estart(1'b0, VEC[i][12:6]);
            exp_w = '0;
            for (int k = 0; k < 8; k++) begin
                b = 8'(16 * i + k + 1);
                exp_w = {exp_w[55:0], b};
                ewr(b);
            end
            hwr(1'b0, 64'(VEC[i][5:0]));
            hrd(1'b1, q);
            chk($sformatf("R6 R7 len=%0d start word", VEC[i][12:6]), q, exp_w);
        end

        // R7: word not stored before its eighth byte
        hwr(1'b0, 64'd62);
        hwr(1'b1, 64'h5555_5555_5555_5555);
        estart(1'b0, 7'd2);
        for (int k = 0; k < 7; k++) ewr(8'hC0 + 8'(k));
        hrd(1'b1, q); chk("R7 partial word not stored", q, 64'h5555_5555_5555_5555);
        ewr(8'hC7);
        hrd(1'b1, q); chk("R7 word stored on eighth byte", q, 64'hC0C1_C2C3_C4C5_C6C7);

        // R8: byte reads across two words of buffer 1
        hwr(1'b0, 64'h1007E);
        hwr(1'b1, 64'h1112_1314_1516_1718);
        hwr(1'b1, 64'h0102_0304_0506_0708);
        estart(1'b1, 7'd2);
        for (int k = 0; k < 8; k++) begin
            erd(b); chk($sformatf("R8 word62 byte %0d", k), 64'(b), 64'(8'h11 + 8'(k)));
        end
        for (int k = 0; k < 7; k++) begin
            erd(b); chk($sformatf("R8 word63 byte %0d", k), 64'(b), 64'(8'h01 + 8'(k)));
        end
        chk("R9 no done before last byte", 64'(eng_done), 64'h0);
        erd(b); chk("R8 word63 byte 7", 64'(b), 64'h08);
        chk("R9 done after last byte", 64'(eng_done), 64'h1);
        @(posedge clk); #1 chk("R9 done single cycle", 64'(eng_done), 64'h0);

        // R9: idle engine ignores strobes
        for (int k = 0; k < 8; k++) ewr(8'hFF);
        chk("R9 no done while idle", 64'(eng_done), 64'h0);
        hwr(1'b0, 64'h0007F);
        hrd(1'b1, q); chk("R9 buf1 w63 untouched", q, 64'h0102_0304_0506_0708);
        hwr(1'b0, 64'h00040);
        hrd(1'b1, q); chk("R9 buf1 w0 untouched", q, 64'hB2B2_0000_0000_0000);

        // R10: same-word collision, engine data kept
        hwr(1'b0, 64'd63);
        estart(1'b0, 7'd1);
        for (int k = 0; k < 7; k++) ewr(8'hE0 + 8'(k));
        @(negedge clk);
        host_addr = 1'b1; host_wdata = 64'h9999_9999_9999_9999; host_wr = 1'b1;
        eng_wr = 1'b1; eng_wbyte = 8'hE7;
        @(posedge clk); #1 host_wr = 1'b0; eng_wr = 1'b0;
        hrd(1'b1, q); chk("R10 engine wins same word", q, 64'hE0E1_E2E3_E4E5_E6E7);

        // R10: different-word collision, both stored
        hwr(1'b0, 64'd5);
        estart(1'b0, 7'd1);
        for (int k = 0; k < 7; k++) ewr(8'h70 + 8'(k));
        @(negedge clk);
        host_addr = 1'b1; host_wdata = 64'h7777_0000_0000_0005; host_wr = 1'b1;
        eng_wr = 1'b1; eng_wbyte = 8'h77;
        @(posedge clk); #1 host_wr = 1'b0; eng_wr = 1'b0;
        hrd(1'b1, q); chk("R10 host word kept", q, 64'h7777_0000_0000_0005);
        hwr(1'b0, 64'd63);
        hrd(1'b1, q); chk("R10 engine word kept", q, 64'h7071_7273_7475_7677);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule